// File: doc/BRIEF.md
# Link Receive Nibble Packer

This block is the receive side of a nibble-wide link. The remote transmitter presents a 4-bit value on the data lines and raises the link clock. The block samples the link clock in the system clock domain through a two-flop synchronizer. On each rising edge it detects, it shifts one nibble into a packing register. The first nibble received becomes the most significant nibble of the word.

A word is complete after 8 nibbles in narrow mode or 12 nibbles in wide mode. It then moves into a two-slot buffer. A DMA engine drains that buffer through a request/read pair. The block drives an acknowledge line back to the transmitter. That line drops while both slots are occupied, which holds the sender off. It returns as soon as a read frees a slot.

Clearing the enable input discards all state:
- buffered words
- any partially packed word
- the status

Top module: `lrx_packer`

## Requirements
- R1: In narrow mode (`wide_mode`=0), 8 nibbles form one word. The first nibble lands in bits [31:28] and the last in bits [3:0].
- R2: In wide mode (`wide_mode`=1), 12 nibbles form one word. The first nibble lands in bits [47:44] and the last in bits [3:0].
- R3: A narrow word is presented on `dma_data` with bits [47:32] equal to zero.
- R4: A nibble is taken only on a rising edge of `link_clk`. Changes on `link_dat` while `link_clk` stays low capture nothing.
- R5: The buffer holds two completed words and delivers them in arrival order. `buf_full` is 1 exactly when both slots are occupied.
- R6: `link_ack` is 0 while the buffer is full. Nibbles that arrive while it is full are discarded and never delivered.
- R7: A DMA read of a full buffer frees a slot, and `link_ack` returns to 1.
- R8: `dma_req` is 1 while at least one word waits. `dma_data` shows the oldest waiting word, and a `dma_rd` pulse removes that word.
- R9: `buf_empty` is 1 when no completed word waits, including just after reset.
- R10: While `enable` is 0, the buffer and the partial word are discarded, and `link_ack`, `dma_req` and `buf_full` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver enable; 0 discards all state |
| wide_mode | input | 1 | 0: 32-bit words, 1: 48-bit words |
| link_clk | input | 1 | Incoming link strobe, asynchronous |
| link_dat | input | 4 | Incoming nibble |
| link_ack | output | 1 | Acknowledge to transmitter; 0 holds it off |
| dma_req | output | 1 | A completed word is waiting |
| dma_rd | input | 1 | Pops the oldest word |
| dma_data | output | 48 | Oldest waiting word |
| buf_full | output | 1 | Both slots occupied |
| buf_empty | output | 1 | No slot occupied |

## Verification
The checker watches the following on every cycle:
- the acknowledge stays low while full;
- the head word holds steady until it is read;
- a read of a full buffer restores the acknowledge;
- a disabled cycle leaves the buffer empty;
- the buffer never jumps from empty to full.

Only the bench scenarios can show the rest. That includes nibble ordering in both widths and the zero upper bits of narrow words. It also includes the loss of nibbles sent into a full buffer and of a partial word cut off by disabling. The scoreboard compares every delivered word against words computed from the requirements.

// File: rtl/lrx_packer.sv
module lrx_packer #(
  parameter int NIB      = 4,
  parameter int W_WIDE   = 48,
  parameter int W_NARROW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wide_mode,
  input  logic              link_clk,
  input  logic [NIB-1:0]    link_dat,
  output logic              link_ack,
  output logic              dma_req,
  input  logic              dma_rd,
  output logic [W_WIDE-1:0] dma_data,
  output logic              buf_full,
  output logic              buf_empty
);
  localparam int NW = W_WIDE / NIB;
  localparam int NN = W_NARROW / NIB;
  localparam int CW = $clog2(NW);

  logic [2:0]          lclk_q;
  logic [NIB-1:0]      dat_q1, dat_q2;
  logic [CW-1:0]       nib_cnt;
  logic [W_WIDE-NIB-1:0] sh;
  logic [W_WIDE-1:0]   slot0, slot1;
  logic [1:0]          cnt;

  wire rise = lclk_q[1] & ~lclk_q[2];
  wire last = wide_mode ? (nib_cnt == CW'(NW-1)) : (nib_cnt == CW'(NN-1));
  wire take = enable && rise && (cnt != 2'd2);
  wire done = take && last;
  wire pop  = enable && dma_rd && (cnt != 2'd0);
  wire [W_WIDE-1:0] word = wide_mode ? {sh, dat_q2}
                         : {{(W_WIDE-W_NARROW){1'b0}}, sh[W_NARROW-NIB-1:0], dat_q2};

  assign link_ack  = enable && (cnt != 2'd2);
  assign dma_req   = (cnt != 2'd0);
  assign buf_full  = (cnt == 2'd2);
  assign buf_empty = (cnt == 2'd0);
  assign dma_data  = slot0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lclk_q <= '0;
      dat_q1 <= '0;
      dat_q2 <= '0;
    end else begin
      lclk_q <= {lclk_q[1:0], link_clk};
      dat_q1 <= link_dat;
      dat_q2 <= dat_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_cnt <= '0;
      sh      <= '0;
    end else if (!enable) begin
      nib_cnt <= '0;
    end else if (take) begin
      sh      <= {sh[W_WIDE-2*NIB-1:0], dat_q2};
      nib_cnt <= last ? '0 : nib_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      slot0 <= '0;
      slot1 <= '0;
    end else if (!enable) begin
      cnt <= '0;
    end else begin
      case ({done, pop})
        2'b10: begin
          if (cnt == 2'd0) slot0 <= word;
          else             slot1 <= word;
          cnt <= cnt + 2'd1;
        end
        2'b01: begin
          slot0 <= slot1;
          cnt   <= cnt - 2'd1;
        end
        2'b11: begin
          if (cnt == 2'd1) slot0 <= word;
          else begin
            slot0 <= slot1;
            slot1 <= word;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module lrx_packer_chk #(parameter int W = 48) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         link_ack,
  input logic         dma_req,
  input logic         dma_rd,
  input logic [W-1:0] dma_data,
  input logic         buf_full,
  input logic         buf_empty
);
  // R6
  full_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !link_ack);
  // R6
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !dma_rd && enable) |=> buf_full);
  // R7
  ack_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && dma_rd && enable) |=> (link_ack || !enable));
  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_rd) |=> $stable(dma_data));
  // R10
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> buf_empty);
  // R9
  no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_empty && enable) |=> !buf_full);
endmodule

bind lrx_packer lrx_packer_chk #(.W(W_WIDE)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .link_ack(link_ack),
  .dma_req(dma_req), .dma_rd(dma_rd), .dma_data(dma_data),
  .buf_full(buf_full), .buf_empty(buf_empty));

// File: tb/lrx_packer_tb.sv
module lrx_packer_tb_top;
  logic        clk = 0, rst_n = 0, enable = 0, wide_mode = 0;
  logic        link_clk = 0, dma_rd = 0, drain = 0;
  logic [3:0]  link_dat = 0;
  logic        link_ack, dma_req, buf_full, buf_empty;
  logic [47:0] dma_data;
  int          nvec = 0, nfail = 0;
  bit          finished = 0;
  logic [47:0] exp_q[$];

  always #2 clk = ~clk;

  lrx_packer dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wide_mode(wide_mode),
    .link_clk(link_clk), .link_dat(link_dat), .link_ack(link_ack),
    .dma_req(dma_req), .dma_rd(dma_rd), .dma_data(dma_data),
    .buf_full(buf_full), .buf_empty(buf_empty));

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops and compares delivered words (R1 R2 R3 R5 R8)
  always @(negedge clk) begin
    if (dma_rd) dma_rd = 0;
    else if (drain && dma_req) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected word", dma_data, 48'h0);
      else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        chk(dma_data === e, "R1/R2/R3/R8 word", dma_data, e);
      end
      dma_rd = 1;
    end
  end

  task automatic send_nib(input logic [3:0] n);
    link_dat = n;
    repeat (3) @(negedge clk);
    link_clk = 1;
    repeat (3) @(negedge clk);
    link_clk = 0;
  endtask

  task automatic send_word(input logic [47:0] w, input bit wide, input bit keep);
    int n;
    n = wide ? 12 : 8;
    wide_mode = wide;
    if (keep) exp_q.push_back(wide ? w : {16'h0, w[31:0]});
    for (int i = 0; i < n; i++) send_nib(w[4*(n-1-i) +: 4]);
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 200 && !buf_empty; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 48'h0, 48'h1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 R10 reset state, disabled
    chk(buf_empty === 1, "R9 empty after reset", 48'(buf_empty), 48'h1);
    chk(dma_req === 0, "R10 no req while disabled", 48'(dma_req), 48'h0);
    chk(link_ack === 0, "R10 ack low while disabled", 48'(link_ack), 48'h0);
    enable = 1;
    @(negedge clk);
    chk(link_ack === 1, "R6 ack high when room", 48'(link_ack), 48'h1);
    // R4 data wiggles while link_clk low: nothing captured
    for (int i = 0; i < 40; i++) begin link_dat = 4'(i); @(negedge clk); end
    chk(buf_empty === 1 && dma_req === 0, "R4 no capture without edge", 48'(buf_empty), 48'h1);
    drain = 1;
    send_word(48'h0000_1234_5678, 0, 1);   // R1 R3
    send_word(48'h0000_F00D_CAFE, 0, 1);   // R1 R3
    send_word(48'hABCD_EF01_2345, 1, 1);   // R2
    send_word(48'h9FFF_FFFF_FFF1, 0, 1);   // R3: upper bits must be zero
    wait_empty();
    chk(exp_q.size() == 0, "R8 all words delivered", 48'(exp_q.size()), 48'h0);
    // R5 R6 fill both slots
    drain = 0;
    send_word(48'h0000_1111_2222, 0, 1);
    chk(buf_empty === 0 && buf_full === 0, "R5 one slot", {buf_full, buf_empty}, 48'h0);
    send_word(48'h0000_3333_4444, 0, 1);
    chk(buf_full === 1, "R5 full after two", 48'(buf_full), 48'h1);
    chk(link_ack === 0, "R6 ack low when full", 48'(link_ack), 48'h0);
    send_word(48'h0000_DEAD_BEEF, 0, 0);   // R6 dropped
    chk(buf_full === 1, "R6 still full", 48'(buf_full), 48'h1);
    drain = 1;
    for (int i = 0; i < 50 && buf_full; i++) @(negedge clk);
    #1;
    chk(link_ack === 1, "R7 ack back after read", 48'(link_ack), 48'h1);
    wait_empty();
    chk(exp_q.size() == 0 && buf_empty === 1, "R6 dropped word absent", 48'(exp_q.size()), 48'h0);
    // R10 disable discards buffered and partial words
    drain = 0;
    send_word(48'h0000_5555_6666, 0, 0);
    send_nib(4'h7); send_nib(4'h8); send_nib(4'h9);
    repeat (4) @(negedge clk);
    enable = 0;
    repeat (2) @(negedge clk);
    chk(buf_empty === 1 && dma_req === 0 && buf_full === 0, "R10 cleared", {buf_full, dma_req, buf_empty}, 48'h1);
    chk(link_ack === 0, "R10 ack low", 48'(link_ack), 48'h0);
    enable = 1;
    drain = 1;
    send_word(48'h0000_A1B2_C3D4, 0, 1);   // R10 partial word gone
    send_word(48'h0123_4567_89AB, 1, 1);   // R2
    wait_empty();
    chk(exp_q.size() == 0, "R10 word after re-enable", 48'(exp_q.size()), 48'h0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule